// File: doc/BRIEF.md
# Bus Write Snooper for Video Memory

This block sits beside a Z80-style parallel bus and watches it without ever driving it. When the processor writes into the top 4 KB of memory, the block captures the write and forwards it to one of two display memories. The lower 2 KB of that window (A11 clear) holds the character codes. The upper 2 KB (A11 set) holds user-defined glyph patterns. An I/O write to one configurable port number sets or clears a glyph-source select bit, which tells the display whether to draw from the fixed font or from the user glyphs. Reads and other bus traffic are ignored.

The bus strobes are asynchronous to the block clock, so every bus input passes through a two-flop synchroniser. A small state machine then takes exactly one capture per bus cycle. It has three states. `S_IDLE` waits for a write strobe. The transition `go_capture` moves it to `S_CAPTURE` when /WR is low together with /MREQ or /IORQ. `S_CAPTURE` classifies the settled cycle and pushes a hit into a FIFO. From there, `go_hold` moves it to `S_HOLD` while /WR stays low, or `go_idle_short` returns it to `S_IDLE` if /WR has already risen. `S_HOLD` takes `go_release` back to `S_IDLE` once /WR rises.

The FIFO drains one entry per clock into single-cycle write strobes. Draining stops while the display side raises `mem_busy`. A combinational active-low strobe also reports the raw window decode for external logic.

Top module: `bus_write_snooper`

## Requirements
- R1: `vram_wr_n` is low exactly when `mreq_n` and `wr_n` are both low and `addr[15:12]` equals 4'hF; otherwise it is high.
- R2: A memory write to 16'hF000–16'hF7FF (addr[11]=0) produces exactly one `text_we` pulse, with `text_addr` = addr[10:0] and `text_data` = the bus data.
- R3: A memory write to 16'hF800–16'hFFFF (addr[11]=1) produces exactly one `glyph_we` pulse, with `glyph_addr` = addr[10:0] and `glyph_data` = the bus data.
- R4: Reads (`wr_n` high), memory writes whose top nibble is not 4'hF, and writes with `mreq_n` high to the window produce no memory strobe.
- R5: A write strobe held low for many clocks still produces only one capture.
- R6: An I/O write (`iorq_n`, `wr_n` low, `mreq_n` high) whose addr[7:0] equals `IO_PORT` loads `glyph_sel` from data bit 0. Other ports, and memory writes, leave `glyph_sel` unchanged, and an I/O write produces no memory strobe.
- R7: While `mem_busy` is high, no memory strobe is issued. Captures taken meanwhile are delivered in bus order, one per clock, after `mem_busy` falls.
- R8: When the FIFO already holds `FIFO_DEPTH` entries, a further capture is dropped, and the stored entries are delivered intact.
- R9: After reset, `text_we` and `glyph_we` are low and `glyph_sel` is 0.
- R10: At most one of `text_we` and `glyph_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| data | input | 8 | Bus data |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_busy | input | 1 | Display side is reading; hold deliveries |
| vram_wr_n | output | 1 | Combinational window write decode, active low |
| text_we | output | 1 | Character memory write pulse |
| text_addr | output | 11 | Character memory offset |
| text_data | output | 8 | Character memory data |
| glyph_we | output | 1 | Glyph memory write pulse |
| glyph_addr | output | 11 | Glyph memory offset |
| glyph_data | output | 8 | Glyph memory data |
| glyph_sel | output | 1 | Glyph-source select bit |

## Verification
The bench builds the block with `FIFO_DEPTH` = 2 and `IO_PORT` = 8'hA5. The shallow FIFO fills after only two held-back writes, so the drop-on-full case and in-order delivery after `mem_busy` falls can be reached in a few bus cycles. The non-default port number shows that the port match comes from the parameter and uses only the low address byte. The neighbouring port 8'hA4 checks that a one-bit mismatch is rejected.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int OFS_W  = 11;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        K_TEXT  = 2'd0,
        K_GLYPH = 2'd1,
        K_PORT  = 2'd2
    } kind_t;

    typedef struct packed {
        kind_t             kind;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
    } cap_t;

    localparam int CAP_W = $bits(cap_t);

endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mreq_n_i,
    input  logic              iorq_n_i,
    input  logic              wr_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              mreq_n_o,
    output logic              iorq_n_o,
    output logic              wr_n_o
);
    localparam int VEC_W = ADDR_W + DATA_W + 3;
    localparam logic [VEC_W-1:0] IDLE_VEC = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [VEC_W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= IDLE_VEC;
                    else        stage_q[0] <= {mreq_n_i, iorq_n_i, wr_n_i, addr_i, data_i};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= IDLE_VEC;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign {mreq_n_o, iorq_n_o, wr_n_o, addr_o, data_o} = stage_q[STAGES-1];

endmodule

// File: rtl/snoop_fsm.sv
module snoop_fsm
    import snoop_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter logic [7:0] IO_PORT = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              mreq_n_s,
    input  logic              iorq_n_s,
    input  logic              wr_n_s,
    output logic              push,
    output cap_t              entry
);
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_CAPTURE = 2'd1,
        S_HOLD    = 2'd2
    } state_t;

    state_t state_q, state_d;

    logic any_wr, mem_hit, io_hit;

    always_comb begin
        any_wr  = !wr_n_s && (!mreq_n_s || !iorq_n_s);
        mem_hit = !mreq_n_s && !wr_n_s && (addr_s[ADDR_W-1 -: 4] == 4'hF);
        io_hit  = mreq_n_s && !iorq_n_s && !wr_n_s && (addr_s[7:0] == IO_PORT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (any_wr) state_d = S_CAPTURE;       // go_capture
            S_CAPTURE: state_d = wr_n_s ? S_IDLE : S_HOLD;    // go_idle_short / go_hold
            S_HOLD:    if (wr_n_s) state_d = S_IDLE;          // go_release
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push       = 1'b0;
        entry.kind = K_TEXT;
        entry.ofs  = addr_s[OFS_W-1:0];
        entry.data = data_s;
        unique case (state_q)
            S_CAPTURE: begin
                if (mem_hit) begin
                    push       = 1'b1;
                    entry.kind = addr_s[OFS_W] ? K_GLYPH : K_TEXT;
                end else if (io_hit) begin
                    push       = 1'b1;
                    entry.kind = K_PORT;
                end
            end
            S_IDLE, S_HOLD: push = 1'b0;
            default:        push = 1'b0;
        endcase
    end

endmodule

// File: rtl/snoop_fifo.sv
module snoop_fifo #(
    parameter int WIDTH = 21,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             wr_ok, rd_ok;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign dout  = mem_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/bus_write_snooper.sv
module bus_write_snooper
    import snoop_pkg::*;
#(
    parameter int         FIFO_DEPTH = 4,
    parameter logic [7:0] IO_PORT    = 8'h40,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [7:0]  data,
    input  logic        mreq_n,
    input  logic        iorq_n,
    input  logic        wr_n,
    input  logic        mem_busy,
    output logic        vram_wr_n,
    output logic        text_we,
    output logic [10:0] text_addr,
    output logic [7:0]  text_data,
    output logic        glyph_we,
    output logic [10:0] glyph_addr,
    output logic [7:0]  glyph_data,
    output logic        glyph_sel
);
    localparam int ADDR_W = 16;

    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              mreq_n_s, iorq_n_s, wr_n_s;
    logic              cap_push;
    cap_t              cap_in, cap_out;
    logic [CAP_W-1:0]  fifo_out;
    logic              fifo_empty, fifo_full, drain;

    // raw window decode toward external logic
    assign vram_wr_n = !(!mreq_n && !wr_n && (addr[15:12] == 4'hF));

    snoop_sync #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .data_i   (data),
        .mreq_n_i (mreq_n),
        .iorq_n_i (iorq_n),
        .wr_n_i   (wr_n),
        .addr_o   (addr_s),
        .data_o   (data_s),
        .mreq_n_o (mreq_n_s),
        .iorq_n_o (iorq_n_s),
        .wr_n_o   (wr_n_s)
    );

    snoop_fsm #(
        .ADDR_W  (ADDR_W),
        .IO_PORT (IO_PORT)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_s   (addr_s),
        .data_s   (data_s),
        .mreq_n_s (mreq_n_s),
        .iorq_n_s (iorq_n_s),
        .wr_n_s   (wr_n_s),
        .push     (cap_push),
        .entry    (cap_in)
    );

    snoop_fifo #(
        .WIDTH (CAP_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cap_push),
        .din   (cap_in),
        .pop   (drain),
        .dout  (fifo_out),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign drain   = !mem_busy && !fifo_empty;
    assign cap_out = cap_t'(fifo_out);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            text_we    <= 1'b0;
            text_addr  <= '0;
            text_data  <= '0;
            glyph_we   <= 1'b0;
            glyph_addr <= '0;
            glyph_data <= '0;
            glyph_sel  <= 1'b0;
        end else begin
            text_we  <= 1'b0;
            glyph_we <= 1'b0;
            if (drain) begin
                unique case (cap_out.kind)
                    K_TEXT: begin
                        text_we   <= 1'b1;
                        text_addr <= cap_out.ofs;
                        text_data <= cap_out.data;
                    end
                    K_GLYPH: begin
                        glyph_we   <= 1'b1;
                        glyph_addr <= cap_out.ofs;
                        glyph_data <= cap_out.data;
                    end
                    K_PORT:  glyph_sel <= cap_out.data[0];
                    default: glyph_sel <= glyph_sel;
                endcase
            end
        end
    end

endmodule

// File: rtl/snoop_checker.sv
module snoop_checker (
    input logic clk,
    input logic rst_n,
    input logic text_we,
    input logic glyph_we,
    input logic glyph_sel,
    input logic mem_busy,
    input logic cap_push
);
    // R10: never both memories in one cycle
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({text_we, glyph_we}));

    // R7: no delivery in the cycle after busy was seen
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |=> !(text_we || glyph_we));

    // R6: a select change never coincides with a memory strobe
    a_r6_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(glyph_sel) |-> !(text_we || glyph_we));

    // R5: a capture is never followed by another in the next cycle
    a_r5_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |=> !cap_push);

endmodule

bind bus_write_snooper snoop_checker i_snoop_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .text_we   (text_we),
    .glyph_we  (glyph_we),
    .glyph_sel (glyph_sel),
    .mem_busy  (mem_busy),
    .cap_push  (cap_push)
);

// File: tb/test_bus_write_snooper.sv
module test_bus_write_snooper;

    localparam int         DEPTH = 2;
    localparam logic [7:0] PORT  = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data = 8'h00;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, wr_n = 1'b1, mem_busy = 1'b0;
    logic        vram_wr_n, text_we, glyph_we, glyph_sel;
    logic [10:0] text_addr, glyph_addr;
    logic [7:0]  text_data, glyph_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // event log: kind 0 = text, 1 = glyph
    int         ev_cnt = 0;
    int         both_cnt = 0;
    logic       ev_kind [64];
    logic [10:0] ev_addr [64];
    logic [7:0]  ev_data [64];

    always #10 clk = ~clk;

    bus_write_snooper #(.FIFO_DEPTH(DEPTH), .IO_PORT(PORT)) i_bus_write_snooper (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data(data),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n), .mem_busy(mem_busy),
        .vram_wr_n(vram_wr_n), .text_we(text_we), .text_addr(text_addr),
        .text_data(text_data), .glyph_we(glyph_we), .glyph_addr(glyph_addr),
        .glyph_data(glyph_data), .glyph_sel(glyph_sel)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (text_we && glyph_we) both_cnt++;
            if ((text_we || glyph_we) && ev_cnt < 64) begin
                ev_kind[ev_cnt] = glyph_we;
                ev_addr[ev_cnt] = glyph_we ? glyph_addr : text_addr;
                ev_data[ev_cnt] = glyph_we ? glyph_data : text_data;
                ev_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        addr = a; data = d; mreq_n = 1'b0; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        mreq_n = 1'b1; wr_n = 1'b1;
        idle(3);
    endtask

    task automatic mem_rd(input logic [15:0] a);
        @(negedge clk);
        addr = a; data = 8'h5A; mreq_n = 1'b0; wr_n = 1'b1;
        idle(4);
        mreq_n = 1'b1;
        idle(3);
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d, input logic mreq);
        @(negedge clk);
        addr = a; data = d; iorq_n = 1'b0; mreq_n = mreq; wr_n = 1'b0;
        idle(3);
        iorq_n = 1'b1; mreq_n = 1'b1; wr_n = 1'b1;
        idle(3);
    endtask

    task automatic expect_ev(input int idx, input logic kind, input logic [10:0] a,
                             input logic [7:0] d, input string req);
        chk(ev_kind[idx] == kind, req, ev_kind[idx], kind);
        chk(ev_addr[idx] == a,    req, ev_addr[idx], a);
        chk(ev_data[idx] == d,    req, ev_data[idx], d);
    endtask

    task automatic t_reset();
        chk(!text_we && !glyph_we, "R9 strobes after reset", {text_we, glyph_we}, 0);
        chk(glyph_sel == 1'b0, "R9 glyph_sel after reset", glyph_sel, 0);
    endtask

    task automatic t_decode();
        @(negedge clk);
        addr = 16'hF123; mreq_n = 1'b0; wr_n = 1'b0;
        #1 chk(vram_wr_n == 1'b0, "R1 window write", vram_wr_n, 0);
        addr = 16'hE123;
        #1 chk(vram_wr_n == 1'b1, "R1 outside window", vram_wr_n, 1);
        addr = 16'hF123; wr_n = 1'b1;
        #1 chk(vram_wr_n == 1'b1, "R1 read", vram_wr_n, 1);
        mreq_n = 1'b1; wr_n = 1'b0;
        #1 chk(vram_wr_n == 1'b1, "R1 no mreq", vram_wr_n, 1);
        wr_n = 1'b1;
        idle(4);
        chk(ev_cnt == 0, "R1 short pulse handled", ev_cnt, 0);
    endtask

    task automatic t_text();
        int base = ev_cnt;
        mem_wr(16'hF000, 8'h41, 2);
        mem_wr(16'hF7FF, 8'hC1, 2);
        idle(4);
        chk(ev_cnt == base + 2, "R2 text count", ev_cnt - base, 2);
        expect_ev(base,     1'b0, 11'h000, 8'h41, "R2 first text");
        expect_ev(base + 1, 1'b0, 11'h7FF, 8'hC1, "R2 last text");
    endtask

    task automatic t_glyph();
        int base = ev_cnt;
        mem_wr(16'hF800, 8'h3C, 2);
        mem_wr(16'hFABC, 8'h81, 2);
        idle(4);
        chk(ev_cnt == base + 2, "R3 glyph count", ev_cnt - base, 2);
        expect_ev(base,     1'b1, 11'h000, 8'h3C, "R3 first glyph");
        expect_ev(base + 1, 1'b1, 11'h2BC, 8'h81, "R3 second glyph");
    endtask

    task automatic t_ignored();
        int base = ev_cnt;
        mem_rd(16'hF010);
        mem_wr(16'hE010, 8'h11, 2);
        mem_wr(16'h7F00, 8'h12, 2);
        io_wr(16'hF010, 8'h13, 1'b1);
        idle(4);
        chk(ev_cnt == base, "R4 no strobe for ignored cycles", ev_cnt - base, 0);
    endtask

    task automatic t_long();
        int base = ev_cnt;
        mem_wr(16'hF0AA, 8'h77, 40);
        idle(4);
        chk(ev_cnt == base + 1, "R5 long write single strobe", ev_cnt - base, 1);
        expect_ev(base, 1'b0, 11'h0AA, 8'h77, "R5 long write content");
    endtask

    task automatic t_port();
        int base = ev_cnt;
        io_wr(16'h00A5, 8'hFF, 1'b1);
        idle(4);
        chk(glyph_sel == 1'b1, "R6 port sets select", glyph_sel, 1);
        io_wr(16'h00A4, 8'h00, 1'b1);
        idle(4);
        chk(glyph_sel == 1'b1, "R6 other port ignored", glyph_sel, 1);
        mem_wr(16'hF0A5, 8'h00, 2);
        idle(4);
        chk(glyph_sel == 1'b1, "R6 memory write keeps select", glyph_sel, 1);
        chk(ev_cnt == base + 1, "R6 only the memory write strobes", ev_cnt - base, 1);
        io_wr(16'h37A5, 8'hFE, 1'b1);
        idle(4);
        chk(glyph_sel == 1'b0, "R6 port clears select", glyph_sel, 0);
        chk(ev_cnt == base + 1, "R6 io write no memory strobe", ev_cnt - base, 1);
    endtask

    task automatic t_busy();
        int base = ev_cnt;
        @(negedge clk) mem_busy = 1'b1;
        mem_wr(16'hF100, 8'hA1, 2);
        mem_wr(16'hF900, 8'hA2, 2);
        idle(6);
        chk(ev_cnt == base, "R7 nothing while busy", ev_cnt - base, 0);
        mem_busy = 1'b0;
        idle(4);
        chk(ev_cnt == base + 2, "R7 delivered after busy", ev_cnt - base, 2);
        expect_ev(base,     1'b0, 11'h100, 8'hA1, "R7 order first");
        expect_ev(base + 1, 1'b1, 11'h100, 8'hA2, "R7 order second");
    endtask

    task automatic t_full();
        int base = ev_cnt;
        @(negedge clk) mem_busy = 1'b1;
        mem_wr(16'hF010, 8'h11, 2);
        mem_wr(16'hF011, 8'h22, 2);
        mem_wr(16'hF012, 8'h33, 2);
        idle(4);
        mem_busy = 1'b0;
        idle(6);
        chk(ev_cnt == base + 2, "R8 overflow dropped", ev_cnt - base, 2);
        expect_ev(base,     1'b0, 11'h010, 8'h11, "R8 kept first");
        expect_ev(base + 1, 1'b0, 11'h011, 8'h22, "R8 kept second");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_decode();
        t_text();
        t_glyph();
        t_ignored();
        t_long();
        t_port();
        t_busy();
        t_full();
        chk(both_cnt == 0, "R10 single target per cycle", both_cnt, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule